// File: doc/BRIEF.md
# Eight-Bit Multifunction GPIO Port

This block is one eight-pin general-purpose I/O port. It holds an output data register and a per-pin direction register, and both are written over a small register bus. Reading the data address returns a per-bit blend. A pin configured as an output reads back its stored register bit. A pin configured as an input reads back its pad level after that level passes through a two-flop synchronizer.

One pin is fixed as an input-only status pin. It is never driven, and its read value always follows the pad. The lowest pin can be claimed as the low-byte write-strobe output: while the bus-width control input is low, that pin drives the strobe level it receives, whatever its direction bit says. A hardware-standby input clears the port and releases every pad. A software-standby input freezes the register contents and blocks register writes.

Top module: `gpio_port8`

## Requirements
- R1: While rst_n is low, the data register, the direction register and both synchronizer stages hold zero. reg_rdata at address 0 then reads 0x00. pad_oe is 0 on every pin except pin 0 when wide_bus is 0.
- R2: A read at reg_sel=0 returns, for each pin other than pin 6 whose direction bit is 1, the stored data register bit.
- R3: For a pin other than pin 6 whose direction bit is 0, the read returns the pad level. A change on pad_in appears on reg_rdata only after the second rising clock edge that follows it.
- R4: Bit 6 of a read always returns the synchronized pin 6 level. Writing bit 6 of the data register has no visible effect. pad_oe[6] is always 0.
- R5: reg_wr with reg_sel=0 loads the data register, and reg_wr with reg_sel=1 loads the direction register. Each write is visible from the next rising edge on. A read with reg_sel=1 returns 0x00, because the direction register cannot be read.
- R6: While hw_stby is high, both registers are cleared at each rising edge and writes are ignored. pad_oe is 0 on all pins, pin 0 included.
- R7: While sw_stby is high and hw_stby is low, both registers keep their contents and writes are ignored.
- R8: When wide_bus is 0 and hw_stby is low, pad_oe[0] is 1 and pad_out[0] equals lwr_n, regardless of direction bit 0.
- R9: When wide_bus is 1, pin 0 behaves as an ordinary port pin: pad_oe[0] equals direction bit 0 and pad_out[0] equals data bit 0.
- R10: For pins 1 to 5 and 7, when hw_stby is low, pad_oe equals the direction bit and pad_out equals the data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby; clears the registers and releases the pads |
| sw_stby | input | 1 | Software standby; holds the registers and blocks writes |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 selects data, 1 selects direction |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| wide_bus | input | 1 | Bus-width control; 0 gives pin 0 to the write strobe |
| lwr_n | input | 1 | Low-byte write-strobe level driven on pin 0 when it is overridden |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |

## Verification
The bench builds the port with its default parameters: eight pins, pin 6 as the read-only pin, pin 0 as the strobe pin, and two synchronizer stages. Under those values, random mixes of direction patterns and pad levels reach every combination of register read-back and pin read-back. The two-edge input latency becomes visible cycle by cycle. Toggling wide_bus and both standby inputs while writes are pending brings the pin-0 takeover and the write blocking into reach together.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int WIDTH       = 8,
  parameter int RO_BIT      = 6,
  parameter int STRB_BIT    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic             wide_bus,
  input  logic             lwr_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);

  localparam logic [WIDTH-1:0] RO_MASK = WIDTH'(1) << RO_BIT;

  logic [WIDTH-1:0] data_q, dir_q, pin_lvl, out_sel;
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];
  logic             wr_ok;

  assign wr_ok = reg_wr & ~hw_stby & ~sw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  data_q <= '0;
    else if (hw_stby)            data_q <= '0;
    else if (wr_ok && !reg_sel)  data_q <= reg_wdata & ~RO_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dir_q <= '0;
    else if (hw_stby)            dir_q <= '0;
    else if (wr_ok && reg_sel)   dir_q <= reg_wdata;
  end

  assign out_sel   = dir_q & ~RO_MASK;
  assign reg_rdata = reg_sel ? '0 : ((out_sel & data_q) | (~out_sel & pin_lvl));

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == RO_BIT) begin : g_ro
      assign pad_oe[i]  = 1'b0;
      assign pad_out[i] = 1'b0;
    end else if (i == STRB_BIT) begin : g_strb
      assign pad_oe[i]  = ~hw_stby & (wide_bus ? dir_q[i] : 1'b1);
      assign pad_out[i] = wide_bus ? data_q[i] : lwr_n;
    end else begin : g_gp
      assign pad_oe[i]  = ~hw_stby & dir_q[i];
      assign pad_out[i] = data_q[i];
    end
  end

  // R6
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (data_q == '0 && dir_q == '0));

  // R7
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> ($stable(data_q) && $stable(dir_q)));

  // R5
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !hw_stby && !sw_stby) |=>
      ((data_q & ~RO_MASK) == ($past(reg_wdata) & ~RO_MASK)));

  // R5
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !hw_stby && !sw_stby) |=> (dir_q == $past(reg_wdata)));

  // R8
  strobe_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_bus && !hw_stby) |-> (pad_oe[STRB_BIT] && pad_out[STRB_BIT] == lwr_n));

  // R4
  ro_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe[RO_BIT]);

endmodule

// File: tb/gpio_port8_tb.sv
module gpio_port8_tb;
  logic       clk = 0, rst_n = 0, hw_stby = 0, sw_stby = 0, reg_wr = 0, reg_sel = 0;
  logic       wide_bus = 1, lwr_n = 1;
  logic [7:0] reg_wdata = 0, pad_in = 0;
  logic [7:0] reg_rdata, pad_oe, pad_out;

  int vecs = 0, errs = 0;
  bit done = 0;
  logic [7:0] m_data = 0, m_dir = 0, m_s1 = 0, m_s2 = 0;

  always #2.5 clk = ~clk;

  gpio_port8 u_dut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wide_bus(wide_bus), .lwr_n(lwr_n), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  function automatic logic [7:0] exp_rd();
    logic [7:0] os = m_dir & 8'hBF;
    if (reg_sel) return 8'h00;
    return (os & m_data) | (~os & m_s2);
  endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] r = m_dir & 8'hBF;
    if (!wide_bus) r[0] = 1'b1;
    if (hw_stby) r = 8'h00;
    return r;
  endfunction

  function automatic logic [7:0] exp_out();
    logic [7:0] r = m_data & 8'hBF;
    if (!wide_bus) r[0] = lwr_n;
    return r;
  endfunction

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp, logic [7:0] care);
    vecs++;
    if ((act & care) !== (exp & care)) begin
      errs++;
      $display("FAIL %s %s act=%02h exp=%02h t=%0t", tag, what, act & care, exp & care, $time);
    end
  endtask

  task automatic step(logic r, logic hs, logic ss, logic wr, logic sel, logic [7:0] wd,
                      logic wb, logic ln, logic [7:0] pi);
    @(negedge clk);
    rst_n = r; hw_stby = hs; sw_stby = ss; reg_wr = wr; reg_sel = sel;
    reg_wdata = wd; wide_bus = wb; lwr_n = ln; pad_in = pi;
    #1;
    if (!rst_n) begin m_data = 0; m_dir = 0; m_s1 = 0; m_s2 = 0; end
    cmp("R2 R3 R4 R5 R1", "rdata", reg_rdata, exp_rd(), 8'hFF);
    cmp("R6 R8 R9 R10 R4 R1", "oe", pad_oe, exp_oe(), 8'hFF);
    cmp("R8 R9 R10", "out", pad_out, exp_out(), exp_oe());
    @(posedge clk);
    if (!rst_n) begin m_data = 0; m_dir = 0; m_s1 = 0; m_s2 = 0; end
    else begin
      m_s2 = m_s1; m_s1 = pad_in;
      if (hw_stby) begin m_data = 0; m_dir = 0; end
      else if (wr && !ss) begin
        if (sel) m_dir = wd; else m_data = wd & 8'hBF;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    // R1 reset state, narrow bus: pin 0 still strobes
    step(0, 0, 0, 0, 0, 8'h00, 0, 0, 8'hA5);
    step(0, 0, 0, 0, 0, 8'h00, 1, 1, 8'hA5);
    // R3 synchronizer latency on inputs
    step(1, 0, 0, 0, 0, 8'h00, 1, 1, 8'h00);
    step(1, 0, 0, 0, 0, 8'h00, 1, 1, 8'hFF);
    step(1, 0, 0, 0, 0, 8'h00, 1, 1, 8'hFF);
    step(1, 0, 0, 0, 0, 8'h00, 1, 1, 8'hFF);
    // R5 R4 write all ones to data and direction; bit 6 ignored
    step(1, 0, 0, 1, 1, 8'hFF, 1, 1, 8'h00);
    step(1, 0, 0, 1, 0, 8'hFF, 1, 1, 8'h00);
    step(1, 0, 0, 0, 0, 8'h00, 1, 1, 8'h00);
    step(1, 0, 0, 0, 1, 8'h00, 1, 1, 8'h00);
    // R8 narrow bus overrides pin 0 with strobe
    step(1, 0, 0, 1, 1, 8'h00, 0, 0, 8'h00);
    step(1, 0, 0, 0, 0, 8'h00, 0, 1, 8'h00);
    step(1, 0, 0, 0, 0, 8'h00, 0, 0, 8'h00);
    // R7 software standby blocks writes
    step(1, 0, 0, 1, 0, 8'h3C, 1, 1, 8'h00);
    step(1, 0, 0, 1, 1, 8'hFF, 1, 1, 8'h00);
    step(1, 0, 1, 1, 0, 8'hC3, 1, 1, 8'h00);
    step(1, 0, 1, 1, 1, 8'h00, 1, 1, 8'h00);
    step(1, 0, 0, 0, 0, 8'h00, 1, 1, 8'h00);
    // R6 hardware standby clears and releases all pads
    step(1, 1, 0, 1, 0, 8'hFF, 0, 1, 8'h00);
    step(1, 1, 0, 0, 0, 8'h00, 0, 1, 8'h00);
    step(1, 0, 0, 0, 0, 8'h00, 1, 1, 8'h00);
    for (int n = 0; n < 4000; n++) begin
      logic hs = ($urandom % 50) == 0;
      logic ss = ($urandom % 8) == 0;
      logic r  = ($urandom % 500) != 0;
      step(r, hs, ss, $urandom % 2, $urandom % 2, 8'($urandom), ($urandom % 3) != 0,
           $urandom % 2, 8'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule